// File: doc/BRIEF.md
# Change-of-State Interrupt Detector

This block watches a set of already-synchronized input lines, grouped into banks of equal width. It compares every line with its value one clock earlier. When a line changes in a direction that is enabled for its bank, the block sets a sticky status bit for that line. Rising and falling detection are enabled separately for each bank, not for each line.

A single level interrupt output stays high while any status bit is set. Host software reads the status one bank at a time or as one packed word. It clears the bits it has handled by writing ones back to them.

All host access goes through a small register port. The write side is one cycle and the read data is combinational. The address map is:

| Address | Read | Write |
|---|---|---|
| 0 | edge-enable byte | edge-enable byte |
| 1 to 4 | status byte of bank 0 to bank 3 | clear the ones written |
| 5 | packed status word | clear the ones written |
| 6 | interrupt level | no effect |

Top module: `cos_irq_detector`

## Requirements
- R1: After reset the enable byte (address 0) reads 0, every status bit reads 0 and `irq_o` is low.
- R2: A write to address 0 loads the enable byte. Bit n enables rising edges for bank n and bit n+4 enables falling edges for bank n. The byte reads back unchanged.
- R3: A 0-to-1 change on a line whose bank has its rising bit set sets that line's status bit on the next clock edge.
- R4: A 1-to-0 change on a line whose bank has its falling bit set sets that line's status bit on the next clock edge.
- R5: With both enable bits of a bank set, a change in either direction on any of its lines is flagged.
- R6: A change on a line whose bank has the matching direction disabled leaves the status unchanged.
- R7: A status bit stays set after the line returns to its old level, until software clears it.
- R8: Writing a byte to address 1+n clears the status bits of bank n that are written as 1. Bits written as 0 keep their value.
- R9: Address 5 reads all status bits as one word, with bank 0 in bits 7:0 and bank 3 in bits 31:24. A write to address 5 clears every status bit that is written as 1.
- R10: `irq_o` is high exactly while any status bit is set. Address 6 reads its level in bit 0, with all other bits 0.
- R11: If an enabled edge on a line and a clear of that line's status bit happen in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lines_i | input | 32 | Synchronized input lines, bank n in bits 8n+7:8n |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench builds the block with its default parameters: four banks of eight lines. This covers the full enable byte, with its rising and falling nibbles, and the packed 32-bit status word. With these values the bench can observe a bank that is disabled in one direction while a neighbouring bank is enabled. It also exercises the top bank, whose status lands in the most significant byte, and a clear that coincides with a fresh edge on the same line.

// File: rtl/cos_pkg.sv
// Package: shared defaults and the address-width rule for the
// change-of-state detector. Assumes nothing beyond elaboration.
package cos_pkg;
    localparam int COS_BANKS  = 4;
    localparam int COS_BANK_W = 8;

    // Address width for the enable, per-bank, word and interrupt slots.
    function automatic int cos_addr_bits(input int banks);
        return $clog2(banks + 3);
    endfunction
endpackage

// File: rtl/cos_edge_bank.sv
// cos_edge_bank: edge detection and sticky status for one bank of lines.
// Assumes lines_i is already synchronous to clk. A set in the same cycle
// as a clear wins.
module cos_edge_bank #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lines_i,
    input  logic              rise_en_i,
    input  logic              fall_en_i,
    input  logic [BANK_W-1:0] clr_i,
    output logic [BANK_W-1:0] status_o
);
    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] status_q;
    logic [BANK_W-1:0] hits;

    // Keep last cycle's line levels; load during reset so no false edge follows.
    always_ff @(posedge clk) begin
        prev_q <= lines_i;
    end

    // Select the enabled transitions of this cycle.
    always_comb begin
        hits = ({BANK_W{rise_en_i}} & lines_i & ~prev_q)
             | ({BANK_W{fall_en_i}} & ~lines_i & prev_q);
    end

    // Sticky status: clear the ones written, then OR in new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_i) | hits;
    end

    assign status_o = status_q;

    AST_RISE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rise_en_i |=> ((status_q & $past(lines_i & ~prev_q)) == $past(lines_i & ~prev_q))); // R3
    AST_FALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        fall_en_i |=> ((status_q & $past(~lines_i & prev_q)) == $past(~lines_i & prev_q))); // R4
    AST_NEW_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_q & ~$past(status_q)) & ~($past(lines_i) ^ $past(prev_q))) == '0)); // R6
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i))); // R7
endmodule

// File: rtl/cos_reg_if.sv
// cos_reg_if: enable register, clear decode and read mux for the detector.
// Assumes one-cycle writes and combinational reads. Address map:
// 0 enable, 1..NUM_BANKS status bytes, then word, then interrupt level.
module cos_reg_if #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3,
    localparam int WORD_W   = NUM_BANKS * BANK_W,
    localparam int EN_W     = 2 * NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    input  logic [WORD_W-1:0] status_i,
    input  logic              irq_i,
    output logic [EN_W-1:0]   en_o,
    output logic [WORD_W-1:0] clr_o,
    output logic [WORD_W-1:0] bus_rdata_o
);
    localparam logic [ADDR_W-1:0] A_EN   = '0;
    localparam logic [ADDR_W-1:0] A_WORD = ADDR_W'(NUM_BANKS + 1);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(NUM_BANKS + 2);

    logic [EN_W-1:0] en_q;

    // Edge-enable register, written at address 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                            en_q <= '0;
        else if (bus_wr_i && bus_addr_i == A_EN) en_q <= bus_wdata_i[EN_W-1:0];
    end

    assign en_o = en_q;

    // Clear mask from per-bank byte writes and from the word write.
    always_comb begin
        clr_o = '0;
        if (bus_wr_i && bus_addr_i == A_WORD) clr_o = bus_wdata_i;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_wr_i && bus_addr_i == ADDR_W'(b + 1))
                clr_o[b*BANK_W +: BANK_W] = bus_wdata_i[BANK_W-1:0];
        end
    end

    // Read mux over the register map.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == A_EN)   bus_rdata_o[EN_W-1:0] = en_q;
        if (bus_addr_i == A_WORD) bus_rdata_o = status_i;
        if (bus_addr_i == A_IRQ)  bus_rdata_o[0] = irq_i;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr_i == ADDR_W'(b + 1))
                bus_rdata_o[BANK_W-1:0] = status_i[b*BANK_W +: BANK_W];
        end
    end

    AST_EN_RESET: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0)); // R1
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_EN) |=> (en_q == $past(bus_wdata_i[EN_W-1:0]))); // R2
endmodule

// File: rtl/cos_irq_detector.sv
// cos_irq_detector: top of the change-of-state detector. It builds one
// edge bank per group of lines, the register interface and the level
// interrupt. Assumes lines_i is synchronized upstream.
module cos_irq_detector #(
    parameter int NUM_BANKS = cos_pkg::COS_BANKS,
    parameter int BANK_W    = cos_pkg::COS_BANK_W,
    localparam int WORD_W   = NUM_BANKS * BANK_W,
    localparam int ADDR_W   = cos_pkg::cos_addr_bits(NUM_BANKS),
    localparam int EN_W     = 2 * NUM_BANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] lines_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    logic [EN_W-1:0]   en;
    logic [WORD_W-1:0] clr;
    logic [WORD_W-1:0] status;

    // One detector per bank; rising enable in bit b, falling in bit b+NUM_BANKS.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        cos_edge_bank #(.BANK_W(BANK_W)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .lines_i   (lines_i[b*BANK_W +: BANK_W]),
            .rise_en_i (en[b]),
            .fall_en_i (en[b+NUM_BANKS]),
            .clr_i     (clr[b*BANK_W +: BANK_W]),
            .status_o  (status[b*BANK_W +: BANK_W])
        );
    end

    // Level interrupt: any pending status bit.
    assign irq_o = |status;

    cos_reg_if #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .status_i    (status),
        .irq_i       (irq_o),
        .en_o        (en),
        .clr_o       (clr),
        .bus_rdata_o (bus_rdata_o)
    );

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !bus_wr_i) |=> irq_o); // R10
    AST_IRQ_RESET: assert property (@(posedge clk)
        !rst_n |=> !irq_o); // R1
endmodule

// File: tb/cos_irq_detector_tb_top.sv
// Scoreboard bench: driver tasks queue expected reads, a monitor compares them.
module cos_irq_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp_data;
        logic        exp_irq;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    cos_irq_detector dut_i (
        .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    // Monitor: compare each queued item 2 ns after the edge that follows its read.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (bus_rdata !== it.exp_data || irq !== it.exp_irq) begin
                n_bad++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.tag, bus_rdata, irq, it.exp_data, it.exp_irq);
            end
        end
    end

    task automatic exp_rd(input logic [2:0] a, input logic [31:0] d,
                          input logic i, input string tag);
        item_t it;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        it.exp_data = d; it.exp_irq = i; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        lines = v;
    endtask

    task automatic wr_and_drive(input logic [2:0] a, input logic [31:0] d,
                                input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; lines = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        exp_rd(3'd0, 32'h0, 1'b0, "R1 enable");
        exp_rd(3'd5, 32'h0, 1'b0, "R1 status word");
        exp_rd(3'd6, 32'h0, 1'b0, "R1 irq level");
        // R2: enable byte layout and readback
        wr(3'd0, 32'hA5);
        exp_rd(3'd0, 32'hA5, 1'b0, "R2 enable readback");
        wr(3'd0, 32'h01);                      // rising, bank 0 only
        // R3: rising edge flagged
        drive(32'h0000_0081);
        exp_rd(3'd5, 32'h0000_0081, 1'b1, "R3 rise bank0");
        // R7 and R6: falling on a rise-only bank is not flagged; bits stay set
        drive(32'h0000_0000);
        exp_rd(3'd5, 32'h0000_0081, 1'b1, "R7 sticky after return");
        drive(32'hFF00_0000);
        exp_rd(3'd5, 32'h0000_0081, 1'b1, "R6 disabled bank3");
        // R8: per-byte write-one-to-clear
        wr(3'd1, 32'h01);
        exp_rd(3'd5, 32'h0000_0080, 1'b1, "R8 clear bit0");
        wr(3'd1, 32'h00);
        exp_rd(3'd1, 32'h0000_0080, 1'b1, "R8 zero write keeps");
        wr(3'd1, 32'h80);
        exp_rd(3'd5, 32'h0, 1'b0, "R8 all cleared");
        exp_rd(3'd6, 32'h0, 1'b0, "R10 irq level low");
        // R4: falling edge on bank 3
        wr(3'd0, 32'h80);
        drive(32'h0F00_0000);
        exp_rd(3'd5, 32'hF000_0000, 1'b1, "R4 fall bank3");
        exp_rd(3'd4, 32'h0000_00F0, 1'b1, "R9 bank3 byte");
        exp_rd(3'd2, 32'h0, 1'b1, "R9 bank1 byte empty");
        exp_rd(3'd6, 32'h1, 1'b1, "R10 irq level high");
        // R5: both directions on bank 1
        wr(3'd0, 32'h22);
        drive(32'h0F00_0300);
        exp_rd(3'd5, 32'hF000_0300, 1'b1, "R5 rise bank1");
        wr(3'd5, 32'hFFFF_FFFF);
        exp_rd(3'd5, 32'h0, 1'b0, "R9 word clear");
        drive(32'h0F00_0100);
        exp_rd(3'd5, 32'h0000_0200, 1'b1, "R5 fall bank1");
        // R11: edge and clear of the same bit in one cycle
        wr_and_drive(3'd5, 32'h0000_0200, 32'h0F00_0300);
        exp_rd(3'd5, 32'h0000_0200, 1'b1, "R11 set wins");
        wr(3'd2, 32'h02);
        exp_rd(3'd5, 32'h0, 1'b0, "R10 irq drops after clear");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule